// File: doc/BRIEF.md
# Four-Channel TDM Sample Port

This block moves 8-bit companded voice samples between four parallel channel ports and a serial time-division multiplexed line. The line has one transmit pin with an output enable and one receive pin. A frame-sync input marks bit 0 of each frame. A frame holds `NSLOTS` slots of 8 bits each, and every slot is sent most significant bit first. Each channel owns one slot. A channel that is powered down leaves its slot undriven and keeps its last received sample.

The line clock is sampled in the system clock domain. It must be synchronous to `clk` and slower than `clk` by at least a factor of four. Two framing modes exist. In PCM mode every line-clock period carries one bit, and each channel's slot number comes from its own configuration field. In the alternative mode each channel's slot comes from two select pins. In that mode the line clock may also run at twice the bit rate, and then only every second rising edge advances the line.

Top module: `tdm_slot_port`

## Requirements
- R1: In PCM mode (`gci_mode`=0) each rising line-clock edge advances the line by one bit. `dout` and `dout_oe` change only on such an advancing edge, and hold their values until the next one.
- R2: The receive pin is sampled on the first falling line-clock edge after an advancing rising edge. The 8 bits of a slot assemble MSB first into the channel's `rx_samples` field.
- R3: In PCM mode, channel i uses slot `pcm_slots[5*i+4:5*i]`. Any slot from 0 to 31 may be used, including the last slot of the frame.
- R4: A rising edge that sees `fsync`=1 makes that bit bit 0 of slot 0. It does this even when it arrives before the previous frame has ended. Within a slot, bit k carries sample bit 7-k.
- R5: With `gci_mode`=1, channel i uses slot 4*`gsel`+i, and `pcm_slots` is ignored.
- R6: With `gci_mode`=1 and `dbl_clk`=1, a rising edge with `fsync`=1 always advances the line. After that, rising edges alternate between skipped and advancing, so each bit spans two line-clock periods.
- R7: `dout_oe` is 0 until the first frame sync. After that it is 1 only during bits of a slot owned by a channel whose `pwr_en` bit is 1.
- R8: A channel with `pwr_en[i]`=0 does not drive its slot, raises no `rx_valid[i]`, and leaves `rx_samples` field i unchanged.
- R9: `rx_valid[i]` is high for exactly one `clk` cycle after the last bit of channel i's slot has been captured, and `rx_samples` field i already holds the new sample in that cycle.
- R10: After reset, `dout_oe`, `rx_valid` and `rx_samples` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Line bit clock, synchronous to clk |
| fsync | input | 1 | Frame sync, sampled on rising bclk |
| din | input | 1 | Serial receive data |
| dout | output | 1 | Serial transmit data |
| dout_oe | output | 1 | Transmit output enable (0 = tri-state) |
| gci_mode | input | 1 | 0 = PCM slot mapping, 1 = pin-selected mapping |
| dbl_clk | input | 1 | In pin-selected mode, bclk is twice the bit rate |
| gsel | input | 2 | Slot group select for pin-selected mode |
| pwr_en | input | 4 | Per-channel power enable |
| pcm_slots | input | 20 | Per-channel PCM slot numbers, 5 bits each |
| tx_samples | input | 32 | Per-channel transmit samples, 8 bits each |
| rx_samples | output | 32 | Per-channel received samples, 8 bits each |
| rx_valid | output | 4 | Per-channel sample-captured strobe |

## Verification
The two functions that can fall in the same cycle are the frame-sync restart of the bit counter and the counter's ordinary increment. The bench provokes this by raising `fsync` only 20 bits into a frame, which is in the middle of channel 2's slot. The restart must win. The scoreboard expects slot 0 to be driven on that same bit, and a full, clean sample for every channel afterwards. In the double-rate mode, a frame sync is also placed on an edge the alternation would have skipped, and that edge must still advance the line.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;
   localparam int GSEL_W = 2;

   typedef enum logic {
      MAP_PCM = 1'b0,
      MAP_PIN = 1'b1
   } map_mode_e;
endpackage

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer
   import tdm_slot_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      bclk,
   input  logic      fsync,
   input  map_mode_e mode,
   input  logic      dbl_clk,
   output logic      tx_tick,
   output logic      rx_tick
);
   logic bclk_q, skip_q, armed_q;
   logic rise, fall, half;

   always_comb begin
      rise    = bclk & ~bclk_q;
      fall    = ~bclk & bclk_q;
      half    = (mode == MAP_PIN) && dbl_clk;
      tx_tick = rise && (!half || fsync || !skip_q);
      rx_tick = fall && armed_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bclk_q  <= 1'b0;
         skip_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         bclk_q <= bclk;
         if (!half)
            skip_q <= 1'b0;
         else if (rise)
            skip_q <= fsync ? 1'b1 : ~skip_q;
         if (tx_tick)
            armed_q <= 1'b1;
         else if (fall)
            armed_q <= 1'b0;
      end
   end
endmodule

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr #(
   parameter int POS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_tick,
   input  logic             fsync,
   output logic [POS_W-1:0] pos,
   output logic [POS_W-1:0] pos_nxt,
   output logic             synced,
   output logic             synced_nxt
);
   always_comb begin
      pos_nxt    = fsync ? '0 : pos + 1'b1;
      synced_nxt = synced | fsync;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos    <= '0;
         synced <= 1'b0;
      end else if (tx_tick) begin
         pos    <= pos_nxt;
         synced <= synced_nxt;
      end
   end
endmodule

// File: rtl/tdm_lane.sv
module tdm_lane #(
   parameter int SW     = 8,
   parameter int SLOT_W = 5,
   parameter int IDX_W  = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    active,
   input  logic [SLOT_W-1:0]       slot,
   input  logic [SLOT_W+IDX_W-1:0] pos,
   input  logic [SLOT_W+IDX_W-1:0] pos_nxt,
   input  logic                    synced,
   input  logic                    synced_nxt,
   input  logic                    rx_tick,
   input  logic                    din,
   input  logic [SW-1:0]           tx_sample,
   output logic                    tx_hit,
   output logic                    tx_bit,
   output logic [SW-1:0]           rx_sample,
   output logic                    rx_vld
);
   localparam int               POS_W = SLOT_W + IDX_W;
   localparam logic [IDX_W-1:0] LAST  = IDX_W'(SW - 1);

   logic [SW-2:0] sh_q;
   logic          rx_hit, rx_last;

   always_comb begin
      tx_hit  = active && synced_nxt && (pos_nxt[POS_W-1:IDX_W] == slot);
      tx_bit  = tx_sample[LAST - pos_nxt[IDX_W-1:0]];
      rx_hit  = active && synced && (pos[POS_W-1:IDX_W] == slot);
      rx_last = (pos[IDX_W-1:0] == LAST);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q      <= '0;
         rx_sample <= '0;
         rx_vld    <= 1'b0;
      end else begin
         rx_vld <= 1'b0;
         if (rx_tick && rx_hit) begin
            sh_q <= {sh_q[SW-3:0], din};
            if (rx_last) begin
               rx_sample <= {sh_q, din};
               rx_vld    <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port
   import tdm_slot_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int SW     = 8,
   parameter int NSLOTS = 32
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               bclk,
   input  logic                               fsync,
   input  logic                               din,
   output logic                               dout,
   output logic                               dout_oe,
   input  logic                               gci_mode,
   input  logic                               dbl_clk,
   input  logic [GSEL_W-1:0]                  gsel,
   input  logic [NCH-1:0]                     pwr_en,
   input  logic [NCH*$clog2(NSLOTS)-1:0]      pcm_slots,
   input  logic [NCH*SW-1:0]                  tx_samples,
   output logic [NCH*SW-1:0]                  rx_samples,
   output logic [NCH-1:0]                     rx_valid
);
   localparam int SLOT_W = $clog2(NSLOTS);
   localparam int IDX_W  = $clog2(SW);
   localparam int POS_W  = SLOT_W + IDX_W;
   localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1;

   if (SW != (1 << IDX_W) || SW < 4) begin : g_bad_sw
      $error("SW must be a power of two of at least 4");
   end
   if (NSLOTS != (1 << SLOT_W)) begin : g_bad_slots
      $error("NSLOTS must be a power of two");
   end
   if (SLOT_W < GSEL_W + CH_W) begin : g_bad_map
      $error("NSLOTS too small for pin-selected slot groups");
   end

   map_mode_e        mode;
   logic             tx_tick, rx_tick;
   logic [POS_W-1:0] pos, pos_nxt;
   logic             synced, synced_nxt;
   logic [NCH-1:0]   hits, bits;

   assign mode = map_mode_e'(gci_mode);

   tdm_bit_timer u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .bclk    (bclk),
      .fsync   (fsync),
      .mode    (mode),
      .dbl_clk (dbl_clk),
      .tx_tick (tx_tick),
      .rx_tick (rx_tick)
   );

   tdm_frame_ctr #(.POS_W(POS_W)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_tick    (tx_tick),
      .fsync      (fsync),
      .pos        (pos),
      .pos_nxt    (pos_nxt),
      .synced     (synced),
      .synced_nxt (synced_nxt)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_lane
      logic [SLOT_W-1:0] slot_i;

      always_comb begin
         if (mode == MAP_PIN)
            slot_i = SLOT_W'({gsel, CH_W'(i)});
         else
            slot_i = pcm_slots[i*SLOT_W +: SLOT_W];
      end

      tdm_lane #(.SW(SW), .SLOT_W(SLOT_W), .IDX_W(IDX_W)) u_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .active     (pwr_en[i]),
         .slot       (slot_i),
         .pos        (pos),
         .pos_nxt    (pos_nxt),
         .synced     (synced),
         .synced_nxt (synced_nxt),
         .rx_tick    (rx_tick),
         .din        (din),
         .tx_sample  (tx_samples[i*SW +: SW]),
         .tx_hit     (hits[i]),
         .tx_bit     (bits[i]),
         .rx_sample  (rx_samples[i*SW +: SW]),
         .rx_vld     (rx_valid[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout    <= 1'b0;
         dout_oe <= 1'b0;
      end else if (tx_tick) begin
         dout    <= |(hits & bits);
         dout_oe <= |hits;
      end
   end
endmodule

// File: rtl/tdm_slot_port_chk.sv
module tdm_slot_port_chk #(
   parameter int NCH = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           tx_tick,
   input logic           rx_tick,
   input logic           synced,
   input logic           dout_oe,
   input logic [NCH-1:0] rx_valid,
   input logic [NCH-1:0] pwr_en
);
   p_oe_hold_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      !tx_tick |=> $stable(dout_oe));

   p_quiet_unsynced_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !synced |-> !dout_oe);

   p_valid_after_sample_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (|rx_valid) |-> $past(rx_tick));

   p_powered_only_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (|rx_valid) |-> ((rx_valid & ~$past(pwr_en)) == '0));

   p_single_pulse_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (|rx_valid) |=> (rx_valid == '0));
endmodule

bind tdm_slot_port tdm_slot_port_chk #(.NCH(NCH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tx_tick  (tx_tick),
   .rx_tick  (rx_tick),
   .synced   (synced),
   .dout_oe  (dout_oe),
   .rx_valid (rx_valid),
   .pwr_en   (pwr_en)
);

// File: tb/tdm_slot_port_tb.sv
module tdm_slot_port_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b0, fsync = 1'b0, din = 1'b0;
   logic        dout, dout_oe;
   logic        gci_mode = 1'b0, dbl_clk = 1'b0;
   logic [1:0]  gsel = 2'd0;
   logic [3:0]  pwr_en = 4'hF;
   logic [19:0] pcm_slots;
   logic [31:0] tx_samples, rx_samples;
   logic [3:0]  rx_valid;

   int          n_cmp = 0, n_bad = 0, n_dbl = 0;
   int          slot_cfg[4];
   logic [7:0]  txpat[4], rxpat[4];
   int          mpos = 0, cur_req = 10;
   bit          msync = 0, mph = 0, eoe = 0, ed = 0;
   logic        din_v = 1'b0;
   logic [3:0]  prev_vld = '0;

   typedef struct { bit oe; bit d; int req; } tx_exp_t;
   typedef struct { int ch; logic [7:0] v; int req; } rx_exp_t;
   tx_exp_t txq[$];
   rx_exp_t rxq[$];

   always #2 clk = ~clk;

   tdm_slot_port u_dut (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .din(din),
      .dout(dout), .dout_oe(dout_oe), .gci_mode(gci_mode), .dbl_clk(dbl_clk),
      .gsel(gsel), .pwr_en(pwr_en), .pcm_slots(pcm_slots),
      .tx_samples(tx_samples), .rx_samples(rx_samples), .rx_valid(rx_valid)
   );

   always_comb begin
      for (int i = 0; i < 4; i++) begin
         pcm_slots[i*5 +: 5]  = 5'(slot_cfg[i]);
         tx_samples[i*8 +: 8] = txpat[i];
      end
   end

   task automatic check(input bit ok, input int req, input string what,
                        input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int chan_for(input int p);
      for (int i = 0; i < 4; i++) begin
         int s;
         s = gci_mode ? (int'(gsel) * 4 + i) : slot_cfg[i];
         if (pwr_en[i] && s == p / 8) return i;
      end
      return -1;
   endfunction

   // one line-clock period; the reference model advances first
   task automatic bit_cyc(input bit fs);
      bit en;
      int c;
      en = !(gci_mode && dbl_clk) || fs || !mph;
      if (gci_mode && dbl_clk) mph = fs ? 1'b1 : !mph;
      else mph = 1'b0;
      if (en) begin
         if (fs) begin mpos = 0; msync = 1; end
         else mpos = (mpos + 1) % 256;
         c = msync ? chan_for(mpos) : -1;
         if (c >= 0) begin
            eoe   = 1;
            ed    = txpat[c][7 - mpos % 8];
            din_v = rxpat[c][7 - mpos % 8];
            if (mpos % 8 == 7)
               rxq.push_back('{c, rxpat[c], (cur_req == 1) ? 2 : cur_req});
         end else begin
            eoe   = 0;
            din_v = mpos[0];
         end
      end
      txq.push_back('{eoe, ed, cur_req});
      @(negedge clk);
      bclk = 1'b1; fsync = fs; din = din_v;
      repeat (4) @(negedge clk);
      bclk = 1'b0; fsync = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic run_bits(input int n, input bit first_fs);
      for (int k = 0; k < n; k++) bit_cyc(first_fs && k == 0);
   endtask

   // transmit monitor: just before each falling line-clock edge
   always @(negedge bclk) begin
      if (txq.size() > 0) begin
         tx_exp_t e;
         e = txq.pop_front();
         if (e.oe)
            check(dout_oe === 1'b1 && dout === e.d, e.req, "tx bit",
                  {dout_oe, dout}, {1'b1, e.d});
         else
            check(dout_oe === 1'b0, e.req, "tx idle oe", dout_oe, 0);
      end
   end

   // receive monitor
   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < 4; i++) begin
            if (rx_valid[i]) begin
               if (prev_vld[i]) n_dbl++;
               if (rxq.size() == 0)
                  check(0, 8, "unexpected rx_valid", i, -1);
               else begin
                  rx_exp_t r;
                  r = rxq.pop_front();
                  check(r.ch == i && rx_samples[i*8 +: 8] === r.v, r.req,
                        "rx sample", {i, rx_samples[i*8 +: 8]}, {r.ch, r.v});
               end
            end
         end
         prev_vld = rx_valid;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog expired: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] hold1, hold3;
      slot_cfg = '{0, 1, 2, 3};
      txpat = '{8'hA5, 8'h3C, 8'h81, 8'h7E};
      rxpat = '{8'h96, 8'hC3, 8'h18, 8'hE7};
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check(dout_oe === 1'b0, 10, "oe after reset", dout_oe, 0);
      check(rx_valid === 4'h0, 10, "valid after reset", rx_valid, 0);
      check(rx_samples === 32'h0, 10, "rx after reset", rx_samples, 0);

      // R7: no drive before the first frame sync
      cur_req = 7;  run_bits(6, 0);
      // R1, R2, R4: PCM default slot order, MSB first
      cur_req = 1;  run_bits(40, 1);
      // R3: scattered slots including the last one
      slot_cfg = '{7, 2, 5, 31};
      txpat = '{8'h0F, 8'hF0, 8'h55, 8'hC9};
      rxpat = '{8'h12, 8'h34, 8'h56, 8'h9B};
      cur_req = 3;  run_bits(256, 1);
      // R8: channels 1 and 3 powered down
      hold1 = rx_samples[15:8];
      hold3 = rx_samples[31:24];
      pwr_en = 4'b0101;
      rxpat = '{8'h6D, 8'hDB, 8'hB6, 8'h4F};
      cur_req = 8;  run_bits(256, 1);
      check(rx_samples[15:8] === hold1, 8, "ch1 rx kept", rx_samples[15:8], hold1);
      check(rx_samples[31:24] === hold3, 8, "ch3 rx kept", rx_samples[31:24], hold3);
      // R4: early frame sync lands inside channel 2's slot
      pwr_en = 4'hF;
      slot_cfg = '{0, 1, 2, 3};
      cur_req = 4;  run_bits(20, 1);
      run_bits(40, 1);
      // R5: pin-selected slot group 2, pcm_slots ignored
      gci_mode = 1'b1; gsel = 2'd2;
      slot_cfg = '{1, 0, 3, 2};
      txpat = '{8'h11, 8'hEE, 8'h5A, 8'hA0};
      cur_req = 5;  run_bits(100, 1);
      // R6: double-rate clock, group 1, then sync on an odd edge
      dbl_clk = 1'b1; gsel = 2'd1;
      cur_req = 6;  run_bits(141, 1);
      run_bits(80, 1);
      repeat (20) @(negedge clk);
      check(txq.size() == 0, 1, "tx queue drained", txq.size(), 0);
      check(rxq.size() == 0, 2, "rx queue drained", rxq.size(), 0);
      check(n_dbl == 0, 9, "rx_valid single pulse", n_dbl, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule